// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits on the bus side of a small processor core. It fetches code bytes ahead of the execution side and keeps them in a short byte FIFO. The decoder takes them one at a time from a pop port. Each fetch address is a 20-bit physical address. It is formed from a 16-bit code segment register and a 16-bit offset register, which holds the byte distance of the next code byte from the segment base. Because segments are 64 KB windows that start on 16-byte boundaries, two different segment/offset pairs can name the same byte.

The memory side is a simple request/acknowledge port whose read data is 16 bits wide. The block starts a fetch only in a bus slot that the operand side leaves free, which it signals with a busy input. Fetching therefore overlaps execution. A jump input loads a new segment and offset. The jump empties the queue at once and throws away any fetch that is still outstanding. The parameter `BUS_WIDE` picks the variant. With the 16-bit bus the queue holds 6 bytes and fetches words. With the 8-bit bus it holds 4 bytes and fetches single bytes.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held, neither `mem_req_o` nor `pop_valid_o` is asserted. After reset the pointer is segment F000h, offset FFF0h, so the first request is to physical address FFFF0h.
- R2: The request address is (segment × 16 + offset) modulo 2^20. For example, segment FFFFh with offset 0020h addresses 00010h.
- R3: The offset advances by the number of bytes fetched and wraps modulo 2^16, staying inside the same segment.
- R4: With `BUS_WIDE`=1, an even address gives a two-byte request (`mem_two_o`=1). Its byte from `mem_rdata_i[7:0]` is queued first, then the byte from `mem_rdata_i[15:8]`. An odd address gives a one-byte request (`mem_two_o`=0) that queues `mem_rdata_i[15:8]` only.
- R5: A two-byte request starts only when at least 2 queue slots are free, and a one-byte request only when at least 1 is free. The queue never holds more than its depth.
- R6: No request starts in a cycle where `bus_busy_i` is 1. Once started, `mem_req_o`, `mem_addr_o` and `mem_two_o` stay unchanged until `mem_ack_i` is seen.
- R7: A cycle with `jump_i`=1 empties the queue, so `pop_valid_o` is 0 in the next cycle. Data acknowledged for a request started before the jump is discarded.
- R8: `pop_valid_o` is 1 exactly when the queue is not empty. A `pop_i` while the queue is empty has no effect. A push and a pop in the same cycle leave the byte count unchanged.
- R9: With `BUS_WIDE`=0 every request is a one-byte request that queues `mem_rdata_i[7:0]`, and the queue holds at most 4 bytes.
- R10: Bytes leave the pop port in ascending offset order, starting at the loaded offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_busy_i | input | 1 | Operand side needs the bus this cycle; no new fetch may start |
| jump_i | input | 1 | Load a new segment and offset, flush the queue |
| jump_seg_i | input | 16 | Code segment loaded on a jump |
| jump_off_i | input | 16 | Offset loaded on a jump |
| mem_req_o | output | 1 | Fetch request, held until acknowledged |
| mem_addr_o | output | 20 | Physical fetch address |
| mem_two_o | output | 1 | 1: two-byte fetch, 0: one-byte fetch |
| mem_ack_i | input | 1 | Request accepted, read data valid this cycle |
| mem_rdata_i | input | 16 | Read data, even byte in the low lane |
| pop_i | input | 1 | Decoder takes the head byte |
| pop_valid_o | output | 1 | Head byte is valid |
| pop_byte_o | output | 8 | Head byte |

## Verification
The bench builds two copies of the block side by side. One has `BUS_WIDE`=1, which gives a 6-byte queue with word fetches and the odd-address single-byte case. The other has `BUS_WIDE`=0, which gives a 4-byte queue filled one byte per request from the low data lane. The wide copy covers the paths that depend on lane choice. These are the 5-byte stall after an odd start, where one slot is left but a word cannot fit, and the even start that fills all 6 bytes. The narrow copy shows that the smaller depth and the fixed low lane follow from the parameter alone.

// File: rtl/pq_pkg.sv
`timescale 1ns/1ps
package pq_pkg;
   localparam int SEG_W = 16;
   localparam int OFF_W = 16;
   localparam int PA_W  = 20;
   localparam logic [SEG_W-1:0] BOOT_SEG = 16'hF000;
   localparam logic [OFF_W-1:0] BOOT_OFF = 16'hFFF0;

   // segment base (16-byte granules) plus offset, folded into 1 MB
   function automatic logic [PA_W-1:0] phys_of(input logic [SEG_W-1:0] seg,
                                               input logic [OFF_W-1:0] off);
      return {seg, 4'h0} + {4'h0, off};
   endfunction

   function automatic int depth_of(input int wide);
      return (wide != 0) ? 6 : 4;
   endfunction
endpackage

// File: rtl/pq_ptr.sv
`timescale 1ns/1ps
module pq_ptr
   import pq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SEG_W-1:0] load_seg_i,
   input  logic [OFF_W-1:0] load_off_i,
   input  logic             adv_i,
   input  logic             adv_two_i,
   output logic [PA_W-1:0]  phys_o
);
   logic [SEG_W-1:0] seg_q;
   logic [OFF_W-1:0] off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= BOOT_SEG;
         off_q <= BOOT_OFF;
      end else if (load_i) begin
         seg_q <= load_seg_i;
         off_q <= load_off_i;
      end else if (adv_i) begin
         off_q <= off_q + (adv_two_i ? OFF_W'(2) : OFF_W'(1));
      end
   end

   assign phys_o = phys_of(seg_q, off_q);
endmodule

// File: rtl/pq_fetch_ctl.sv
`timescale 1ns/1ps
module pq_fetch_ctl
   import pq_pkg::*;
#(
   parameter int WIDE  = 1,
   parameter int DEPTH = 6,
   parameter int CNT_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             load_i,
   input  logic [PA_W-1:0]  phys_i,
   input  logic [CNT_W-1:0] fill_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic [PA_W-1:0]  addr_o,
   output logic             two_o,
   output logic             take_o
);
   logic             pend_q, drop_q, two_q;
   logic [PA_W-1:0]  addr_q;
   logic             want_two, room, start;
   logic [CNT_W-1:0] free_w;

   generate
      if (WIDE != 0) begin : g_wide
         assign want_two = ~phys_i[0];
      end else begin : g_narrow
         assign want_two = 1'b0;
      end
   endgenerate

   assign free_w = CNT_W'(DEPTH) - fill_i;
   assign room   = want_two ? (free_w >= CNT_W'(2)) : (free_w != '0);
   assign start  = !pend_q && !busy_i && !load_i && room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         drop_q <= 1'b0;
         two_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         if (pend_q && ack_i) begin
            pend_q <= 1'b0;
            drop_q <= 1'b0;
         end else if (start) begin
            pend_q <= 1'b1;
            addr_q <= phys_i;
            two_q  <= want_two;
         end
         if (load_i && pend_q && !ack_i)
            drop_q <= 1'b1;
      end
   end

   assign req_o  = pend_q;
   assign addr_o = addr_q;
   assign two_o  = two_q;
   assign take_o = pend_q && ack_i && !drop_q && !load_i;
endmodule

// File: rtl/pq_byte_fifo.sv
`timescale 1ns/1ps
module pq_byte_fifo #(
   parameter int DEPTH = 6,
   parameter int CNT_W = 3,
   parameter int PTR_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             push_i,
   input  logic             push_two_i,
   input  logic [7:0]       b0_i,
   input  logic [7:0]       b1_i,
   input  logic             pop_i,
   output logic             valid_o,
   output logic [7:0]       head_o,
   output logic [CNT_W-1:0] fill_o
);
   logic [7:0]       slot [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] fill_q;
   logic             pop_ok;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   assign pop_ok = pop_i && (fill_q != '0);

   always_ff @(posedge clk) begin
      if (push_i && !flush_i) begin
         slot[wr_q] <= b0_i;
         if (push_two_i)
            slot[nxt(wr_q)] <= b1_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         fill_q <= '0;
      end else if (flush_i) begin
         wr_q   <= '0;
         rd_q   <= '0;
         fill_q <= '0;
      end else begin
         if (push_i)
            wr_q <= push_two_i ? nxt(nxt(wr_q)) : nxt(wr_q);
         if (pop_ok)
            rd_q <= nxt(rd_q);
         fill_q <= fill_q
                 + (push_i ? (push_two_i ? CNT_W'(2) : CNT_W'(1)) : CNT_W'(0))
                 - (pop_ok ? CNT_W'(1) : CNT_W'(0));
      end
   end

   assign valid_o = (fill_q != '0);
   assign head_o  = slot[rd_q];
   assign fill_o  = fill_q;
endmodule

// File: rtl/prefetch_queue.sv
`timescale 1ns/1ps
module prefetch_queue
   import pq_pkg::*;
#(
   parameter int BUS_WIDE = 1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_busy_i,
   input  logic        jump_i,
   input  logic [15:0] jump_seg_i,
   input  logic [15:0] jump_off_i,
   output logic        mem_req_o,
   output logic [19:0] mem_addr_o,
   output logic        mem_two_o,
   input  logic        mem_ack_i,
   input  logic [15:0] mem_rdata_i,
   input  logic        pop_i,
   output logic        pop_valid_o,
   output logic [7:0]  pop_byte_o
);
   localparam int DEPTH = depth_of(BUS_WIDE);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = $clog2(DEPTH);

   generate
      if (BUS_WIDE != 0 && BUS_WIDE != 1) begin : g_bad_param
         $error("prefetch_queue: BUS_WIDE must be 0 or 1");
      end
   endgenerate

   logic [PA_W-1:0]  phys_w;
   logic [CNT_W-1:0] q_fill;
   logic             take_w;
   logic [7:0]       lane0, lane1;

   pq_ptr u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (jump_i),
      .load_seg_i (jump_seg_i),
      .load_off_i (jump_off_i),
      .adv_i      (take_w),
      .adv_two_i  (mem_two_o),
      .phys_o     (phys_w)
   );

   pq_fetch_ctl #(.WIDE(BUS_WIDE), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (bus_busy_i),
      .load_i (jump_i),
      .phys_i (phys_w),
      .fill_i (q_fill),
      .ack_i  (mem_ack_i),
      .req_o  (mem_req_o),
      .addr_o (mem_addr_o),
      .two_o  (mem_two_o),
      .take_o (take_w)
   );

   generate
      if (BUS_WIDE != 0) begin : g_lanes_wide
         // single-byte fetches are always odd, so they ride the high lane
         assign lane0 = mem_two_o ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
         assign lane1 = mem_rdata_i[15:8];
      end else begin : g_lanes_narrow
         assign lane0 = mem_rdata_i[7:0];
         assign lane1 = mem_rdata_i[15:8];
      end
   endgenerate

   pq_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (jump_i),
      .push_i     (take_w),
      .push_two_i (mem_two_o),
      .b0_i       (lane0),
      .b1_i       (lane1),
      .pop_i      (pop_i),
      .valid_o    (pop_valid_o),
      .head_o     (pop_byte_o),
      .fill_o     (q_fill)
   );
endmodule

// File: rtl/pq_checker.sv
`timescale 1ns/1ps
module pq_checker #(
   parameter int DEPTH = 6,
   parameter int CNT_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             jump,
   input logic             req,
   input logic [19:0]      addr,
   input logic             two,
   input logic             ack,
   input logic             pop_valid,
   input logic [CNT_W-1:0] fill
);
   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req && $stable(addr) && $stable(two));

   a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !req && busy |=> !req);

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
      jump |=> !pop_valid);

   a_r4_odd_single: assert property (@(posedge clk) disable iff (!rst_n)
      req && addr[0] |-> !two);
endmodule

bind prefetch_queue pq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (bus_busy_i),
   .jump      (jump_i),
   .req       (mem_req_o),
   .addr      (mem_addr_o),
   .two       (mem_two_o),
   .ack       (mem_ack_i),
   .pop_valid (pop_valid_o),
   .fill      (q_fill)
);

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;
   logic clk = 1'b0;
   always #5 clk = ~clk;
   logic rst_n;

   logic w_busy, w_jump, w_req, w_two, w_pop, w_valid, w_hold;
   logic w_ack = 1'b0;
   logic [15:0] w_seg, w_off;
   logic [15:0] w_rdata = '0;
   logic [19:0] w_addr;
   logic [7:0]  w_byte;

   logic n_busy, n_jump, n_req, n_two, n_pop, n_valid;
   logic n_ack = 1'b0;
   logic [15:0] n_seg, n_off;
   logic [15:0] n_rdata = '0;
   logic [19:0] n_addr;
   logic [7:0]  n_byte;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   prefetch_queue #(.BUS_WIDE(1)) i_prefetch_queue (
      .clk(clk), .rst_n(rst_n), .bus_busy_i(w_busy), .jump_i(w_jump),
      .jump_seg_i(w_seg), .jump_off_i(w_off), .mem_req_o(w_req),
      .mem_addr_o(w_addr), .mem_two_o(w_two), .mem_ack_i(w_ack),
      .mem_rdata_i(w_rdata), .pop_i(w_pop), .pop_valid_o(w_valid),
      .pop_byte_o(w_byte));

   prefetch_queue #(.BUS_WIDE(0)) i_prefetch_queue_n (
      .clk(clk), .rst_n(rst_n), .bus_busy_i(n_busy), .jump_i(n_jump),
      .jump_seg_i(n_seg), .jump_off_i(n_off), .mem_req_o(n_req),
      .mem_addr_o(n_addr), .mem_two_o(n_two), .mem_ack_i(n_ack),
      .mem_rdata_i(n_rdata), .pop_i(n_pop), .pop_valid_o(n_valid),
      .pop_byte_o(n_byte));

   function automatic logic [7:0] mbyte(input logic [19:0] a);
      return a[7:0] ^ {a[15:12], a[11:8]} ^ {a[19:16], 4'h3};
   endfunction

   function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
      return {s, 4'h0} + {4'h0, o};
   endfunction

   // memory models: answer one cycle after a request appears
   always @(posedge clk) begin
      #1;
      if (w_req && !w_ack && !w_hold) begin
         w_ack   <= 1'b1;
         w_rdata <= {mbyte({w_addr[19:1], 1'b1}), mbyte({w_addr[19:1], 1'b0})};
      end else w_ack <= 1'b0;
   end

   always @(posedge clk) begin
      #1;
      if (n_req && !n_ack) begin
         n_ack   <= 1'b1;
         n_rdata <= {8'hEE, mbyte(n_addr)};
      end else n_ack <= 1'b0;
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic set_pop(input bit nar, input logic v);
      if (nar) n_pop = v; else w_pop = v;
   endtask

   task automatic jump(input bit nar, input logic [15:0] s, input logic [15:0] o);
      if (nar) begin n_jump = 1; n_seg = s; n_off = o; n_pop = 0; end
      else begin w_jump = 1; w_seg = s; w_off = o; w_pop = 0; end
      @(negedge clk);
      if (nar) n_jump = 0; else w_jump = 0;
      chk(!(nar ? n_valid : w_valid), "R7", 32'(nar ? n_valid : w_valid), 0);
   endtask

   task automatic stream(input bit nar, input logic [15:0] s, input logic [15:0] o,
                         input int n, input string rq);
      int got = 0;
      int guard = 0;
      logic [15:0] oo;
      logic [7:0] e, a;
      while (got < n && guard < 2000) begin
         if (nar ? n_valid : w_valid) begin
            oo = o + 16'(got);
            e = mbyte(pa(s, oo));
            a = nar ? n_byte : w_byte;
            chk(a == e, rq, {24'h0, a}, {24'h0, e});
            got++;
            set_pop(nar, 1'b1);
         end else set_pop(nar, 1'b0);
         if (nar && n_req && n_two) chk(1'b0, "R9", 32'(n_two), 0);
         guard++;
         @(negedge clk);
      end
      set_pop(nar, 1'b0);
      if (got < n) chk(1'b0, rq, 32'(got), 32'(n));
   endtask

   // {segment, offset, bytes to pop}
   localparam logic [47:0] VEC [6] = '{
      {16'hF000, 16'hFFF0, 16'd20},
      {16'h123A, 16'h341B, 16'd9},
      {16'hFFFF, 16'h0020, 16'd12},
      {16'h0001, 16'hFFFB, 16'd10},
      {16'h0000, 16'h0000, 16'd8},
      {16'hA820, 16'hCE24, 16'd7}
   };

   initial begin
      int guard;
      rst_n = 0; w_busy = 0; w_jump = 0; w_seg = 0; w_off = 0; w_pop = 0; w_hold = 1;
      n_busy = 0; n_jump = 0; n_seg = 0; n_off = 0; n_pop = 0;
      repeat (3) @(negedge clk);
      chk(!w_req && !w_valid && !n_req && !n_valid, "R1", {28'h0, w_req, w_valid, n_req, n_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(w_req && w_addr == 20'hFFFF0, "R1", {11'h0, w_req, w_addr}, 32'h1FFFF0);
      chk(w_two == 1'b1, "R4", 32'(w_two), 1);
      repeat (2) @(negedge clk);
      chk(w_req && w_addr == 20'hFFFF0 && w_two, "R6", {11'h0, w_req, w_addr}, 32'h1FFFF0);
      w_hold = 0;
      stream(0, 16'hF000, 16'hFFF0, 6, "R1");

      // table of jump targets
      for (int i = 0; i < 6; i++) begin
         jump(0, VEC[i][47:32], VEC[i][31:16]);
         stream(0, VEC[i][47:32], VEC[i][31:16], int'(VEC[i][15:0]), "R2 R3 R10");
      end

      // R4: odd start gives one high-lane byte, then word fetches
      jump(0, 16'h7000, 16'h0003);
      @(negedge clk);
      chk(w_req && w_addr == 20'h70003 && !w_two, "R4", {10'h0, w_req, w_two, w_addr}, 32'h270003);
      guard = 0;
      while (!(w_req && w_addr == 20'h70004) && guard < 10) begin @(negedge clk); guard++; end
      chk(w_two == 1'b1 && guard < 10, "R4", 32'(w_two), 1);
      stream(0, 16'h7000, 16'h0003, 6, "R4");

      // R5: odd start stalls at 5 bytes, even start fills 6
      jump(0, 16'h5000, 16'h0001);
      repeat (20) @(negedge clk);
      chk(!w_req, "R5", 32'(w_req), 0);
      w_busy = 1;
      stream(0, 16'h5000, 16'h0001, 5, "R5");
      chk(!w_valid, "R5", 32'(w_valid), 0);
      w_busy = 0;
      jump(0, 16'h5000, 16'h0000);
      repeat (20) @(negedge clk);
      chk(!w_req, "R5", 32'(w_req), 0);
      w_busy = 1;
      stream(0, 16'h5000, 16'h0000, 6, "R5");
      chk(!w_valid, "R5", 32'(w_valid), 0);

      // R6: busy bus blocks new fetches
      jump(0, 16'h4000, 16'h0000);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!w_req && !w_valid, "R6", {30'h0, w_req, w_valid}, 0);
      end
      w_busy = 0;
      stream(0, 16'h4000, 16'h0000, 6, "R6");

      // R7: jump while a fetch is outstanding discards its data
      w_hold = 1;
      jump(0, 16'h2000, 16'h0000);
      repeat (2) @(negedge clk);
      chk(w_req && w_addr == 20'h20000, "R6", {11'h0, w_req, w_addr}, 32'h120000);
      jump(0, 16'h3000, 16'h0011);
      w_hold = 0;
      stream(0, 16'h3000, 16'h0011, 8, "R7");

      // R8: pop on an empty queue is ignored
      w_busy = 1;
      jump(0, 16'h6000, 16'h0002);
      w_pop = 1;
      repeat (3) @(negedge clk);
      w_pop = 0;
      chk(!w_valid, "R8", 32'(w_valid), 0);
      w_busy = 0;
      stream(0, 16'h6000, 16'h0002, 4, "R8");

      // R9: narrow variant, full at 4 bytes since reset
      chk(!n_req && n_valid, "R9", {30'h0, n_req, n_valid}, 1);
      n_busy = 1;
      stream(1, 16'hF000, 16'hFFF0, 4, "R9");
      chk(!n_valid, "R9", 32'(n_valid), 0);
      n_busy = 0;
      jump(1, 16'h1234, 16'h5679);
      stream(1, 16'h1234, 16'h5679, 7, "R9");

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule